// File: doc/BRIEF.md
# Random-number peripheral interrupt controller

This block gathers the interrupt sources of a random-number peripheral into one level interrupt line. It works in two layers. Three core flags (certification fault, health-test fault and generation done) each have an enable. The OR of every flag that is set and also enabled forms the core interrupt bit. That bit and a bus slave-error bit make up a top status register. The top status register is write-one-to-clear, and it sits behind a mask. The mask is changed only through separate enable and disable write strobes.

Fault events reach the core flags only while the entropy source is running. On hardware older than version 0x0200, the certification fault also needs the quick-test unit to be enabled. The bus decoder in front of the block and the logic that produces the events are outside the block. Writes arrive as a strobe plus data per register, and events arrive as one-cycle pulses.

Top module: `rng_irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the core flags, the flag enables and the top status are all zero, the mask is 2'b11 and irq is low.
- R2: A done pulse sets core_flags[0] at the next clock edge, whatever the state of the entropy source. core_flags bit 2 is the certification fault, bit 1 is the health-test fault and bit 0 is done.
- R3: Fault pulses are ignored while the entropy source is inactive. The source is inactive when soft_rst is high, src_en is low or osc_en is low.
- R4: When HW_VERSION is below 0x0200 (the default is 0x0100), a certification-fault pulse is ignored unless qtu_en is high. The health-test fault is not affected.
- R5: A control write loads the flag enables from ctl_wdata[2:0] (bit 2 certification, bit 1 health, bit 0 done). A 1 in ctl_wdata[5], [4] or [3] clears the certification, health or done flag. If an event for the same flag arrives in the same cycle, the event wins.
- R6: Each control write, each accepted fault and each done pulse recomputes top_status[0]. The new value is the OR, over the three flags, of the flag AND its enable, both taken as they stand after that clock edge.
- R7: The top status is write-one-to-clear. Bit 1 is the slave error and bit 0 is the core interrupt. When a slave-error pulse meets a clear of bit 1 in the same cycle, the pulse wins. A recompute of bit 0 takes precedence over a clear of bit 0.
- R8: A write to the enable strobe clears the mask bits that are 1 in its data. A write to the disable strobe sets them. When both touch the same bit in the same cycle, the disable wins. Nothing else changes the mask.
- R9: irq is high in the cycle after the top status holds a 1 at a bit position whose mask bit is 0, and is low otherwise.
- R10: While soft_rst is high, the core flags and top_status[0] are cleared. The mask, the flag enables and top_status[1] are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control data: [5:3] flag clears, [2:0] flag enables |
| sts_we | input | 1 | Top status write strobe (write-one-to-clear) |
| sts_wdata | input | 2 | Top status clear bits |
| unmask_we | input | 1 | Enable strobe; clears mask bits |
| unmask_wdata | input | 2 | Mask bits to clear |
| mask_we | input | 1 | Disable strobe; sets mask bits |
| mask_wdata | input | 2 | Mask bits to set |
| soft_rst | input | 1 | Soft reset level of the generator |
| src_en | input | 1 | Entropy source enable |
| osc_en | input | 1 | Oscillator enable |
| qtu_en | input | 1 | Quick-test unit enable |
| cert_fault_ev | input | 1 | Certification fault pulse |
| hlth_fault_ev | input | 1 | Health-test fault pulse |
| done_ev | input | 1 | Generation done pulse |
| slv_err_ev | input | 1 | Bus slave error pulse |
| core_flags | output | 3 | Core flags {cert, health, done} |
| flag_en | output | 3 | Core flag enables |
| top_status | output | 2 | Top status {slave error, core interrupt} |
| mask | output | 2 | Interrupt mask |
| irq | output | 1 | Level interrupt line |

## Verification
The hardest situations to reach are the same-cycle collisions. One is an event arriving in the same cycle as a clear of its own flag. Another is a write-one-to-clear of the core interrupt bit that coincides with a recompute, where the recompute must decide the result. The stimulus drives these by raising a control write, or a status clear, together with the matching event pulse on a single clock edge. It also drives a disable and an enable strobe on the same mask bit at once. The version gate and the source gate are covered by sending fault pulses with each gating input low in turn, and then again with all of them high.

// File: rtl/rng_irq_pkg.sv
package rng_irq_pkg;
  localparam int unsigned NCORE  = 3;
  localparam int unsigned NTOP   = 2;
  localparam int unsigned CF_DONE = 0;
  localparam int unsigned CF_HLTH = 1;
  localparam int unsigned CF_CERT = 2;
  localparam int unsigned TS_CORE = 0;
  localparam int unsigned TS_SLV  = 1;
  localparam int unsigned CTL_W   = 2 * NCORE;
  localparam logic [15:0] VER_NO_QTU_GATE = 16'h0200;
endpackage

// File: rtl/rng_core_flags.sv
module rng_core_flags #(
  parameter int unsigned N = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           ctl_we,
  input  logic [2*N-1:0] ctl_wdata,
  input  logic [N-1:0]   set_req,
  output logic [N-1:0]   flags_q,
  output logic [N-1:0]   en_q,
  output logic           pend_nxt,
  output logic           recompute
);
  logic [N-1:0] flags_d;
  logic [N-1:0] en_d;

  always_comb begin
    en_d = ctl_we ? ctl_wdata[N-1:0] : en_q;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_flag
      logic clr;
      always_comb begin
        clr = ctl_we & ctl_wdata[N+gi];
        if (soft_rst) flags_d[gi] = 1'b0;
        else          flags_d[gi] = set_req[gi] | (flags_q[gi] & ~clr);
      end
    end
  endgenerate

  always_comb begin
    pend_nxt  = |(flags_d & en_d);
    recompute = ctl_we | (|set_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (ctl_we) begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/rng_top_irq.sv
module rng_top_irq #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] load_en,
  input  logic [N-1:0] load_val,
  input  logic         w1c_we,
  input  logic [N-1:0] w1c_data,
  input  logic         unmask_we,
  input  logic [N-1:0] unmask_data,
  input  logic         mask_we,
  input  logic [N-1:0] mask_data,
  output logic [N-1:0] status_q,
  output logic [N-1:0] mask_q,
  output logic         irq_q
);
  logic [N-1:0] status_d;
  logic [N-1:0] mask_d;
  logic         irq_d;
  logic         mask_ce;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_sts
      logic clr;
      always_comb begin
        clr = w1c_we & w1c_data[gi];
        if (load_en[gi]) status_d[gi] = load_val[gi];
        else             status_d[gi] = set_vec[gi] | (status_q[gi] & ~clr);
      end
    end
  endgenerate

  always_comb begin
    mask_ce = unmask_we | mask_we;
    mask_d  = mask_q;
    if (unmask_we) mask_d = mask_d & ~unmask_data;
    if (mask_we)   mask_d = mask_d | mask_data;
    irq_d   = |(status_q & ~mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_ce) begin
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/rng_irq_ctrl.sv
module rng_irq_ctrl
  import rng_irq_pkg::*;
#(
  parameter logic [15:0] HW_VERSION = 16'h0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             sts_we,
  input  logic [NTOP-1:0]  sts_wdata,
  input  logic             unmask_we,
  input  logic [NTOP-1:0]  unmask_wdata,
  input  logic             mask_we,
  input  logic [NTOP-1:0]  mask_wdata,
  input  logic             soft_rst,
  input  logic             src_en,
  input  logic             osc_en,
  input  logic             qtu_en,
  input  logic             cert_fault_ev,
  input  logic             hlth_fault_ev,
  input  logic             done_ev,
  input  logic             slv_err_ev,
  output logic [NCORE-1:0] core_flags,
  output logic [NCORE-1:0] flag_en,
  output logic [NTOP-1:0]  top_status,
  output logic [NTOP-1:0]  mask,
  output logic             irq
);
  localparam bit CERT_UNGATED = (HW_VERSION >= VER_NO_QTU_GATE);

  logic             src_active;
  logic             cert_ok;
  logic [NCORE-1:0] set_req;
  logic             pend_nxt;
  logic             recompute;
  logic [NTOP-1:0]  set_vec;
  logic [NTOP-1:0]  load_en;
  logic [NTOP-1:0]  load_val;

  always_comb begin
    src_active = ~soft_rst & src_en & osc_en;
    cert_ok    = src_active & (CERT_UNGATED | qtu_en);
    set_req           = '0;
    set_req[CF_DONE]  = done_ev;
    set_req[CF_HLTH]  = hlth_fault_ev & src_active;
    set_req[CF_CERT]  = cert_fault_ev & cert_ok;
  end

  rng_core_flags #(.N(NCORE)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .set_req   (set_req),
    .flags_q   (core_flags),
    .en_q      (flag_en),
    .pend_nxt  (pend_nxt),
    .recompute (recompute)
  );

  always_comb begin
    set_vec           = '0;
    load_en           = '0;
    load_val          = '0;
    set_vec[TS_SLV]   = slv_err_ev;
    load_en[TS_CORE]  = soft_rst | recompute;
    load_val[TS_CORE] = ~soft_rst & pend_nxt;
  end

  rng_top_irq #(.N(NTOP)) u_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_vec     (set_vec),
    .load_en     (load_en),
    .load_val    (load_val),
    .w1c_we      (sts_we),
    .w1c_data    (sts_wdata),
    .unmask_we   (unmask_we),
    .unmask_data (unmask_wdata),
    .mask_we     (mask_we),
    .mask_data   (mask_wdata),
    .status_q    (top_status),
    .mask_q      (mask),
    .irq_q       (irq)
  );
endmodule

// File: rtl/rng_irq_ctrl_chk.sv
module rng_irq_ctrl_chk #(
  parameter logic [15:0] HW_VERSION = 16'h0100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       unmask_we,
  input logic [1:0] unmask_wdata,
  input logic       mask_we,
  input logic [1:0] mask_wdata,
  input logic       soft_rst,
  input logic       src_en,
  input logic       osc_en,
  input logic       qtu_en,
  input logic [2:0] core_flags,
  input logic [1:0] top_status,
  input logic [1:0] mask,
  input logic       irq
);
  localparam bit OLD_HW = (HW_VERSION < 16'h0200);

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(top_status & ~mask)));  // R9

  AST_UNMASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (unmask_we && !mask_we) |=> (mask & $past(unmask_wdata)) == 2'b00);  // R8

  AST_MASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask & $past(mask_wdata)) == $past(mask_wdata));  // R8

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!unmask_we && !mask_we) |=> $stable(mask));  // R8

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (core_flags == 3'b000) && !top_status[0]);  // R10

  AST_SOFT_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !unmask_we && !mask_we) |=> $stable(mask));  // R10

  AST_FAULT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((soft_rst || !src_en || !osc_en) && !core_flags[1]) |=> !core_flags[1]);  // R3

  AST_CERT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((soft_rst || !src_en || !osc_en || (OLD_HW && !qtu_en)) && !core_flags[2])
      |=> !core_flags[2]);  // R4
endmodule

bind rng_irq_ctrl rng_irq_ctrl_chk #(.HW_VERSION(HW_VERSION)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .unmask_we    (unmask_we),
  .unmask_wdata (unmask_wdata),
  .mask_we      (mask_we),
  .mask_wdata   (mask_wdata),
  .soft_rst     (soft_rst),
  .src_en       (src_en),
  .osc_en       (osc_en),
  .qtu_en       (qtu_en),
  .core_flags   (core_flags),
  .top_status   (top_status),
  .mask         (mask),
  .irq          (irq)
);

// File: tb/tb_rng_irq_ctrl.sv
`timescale 1ns/1ps
module tb_rng_irq_ctrl;
  localparam int HWV = 16'h0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 0; logic [5:0] ctl_wdata = 0;
  logic sts_we = 0; logic [1:0] sts_wdata = 0;
  logic unmask_we = 0; logic [1:0] unmask_wdata = 0;
  logic mask_we = 0; logic [1:0] mask_wdata = 0;
  logic soft_rst = 0, src_en = 0, osc_en = 0, qtu_en = 0;
  logic cert_fault_ev = 0, hlth_fault_ev = 0, done_ev = 0, slv_err_ev = 0;
  logic [2:0] core_flags, flag_en;
  logic [1:0] top_status, mask;
  logic irq;

  rng_irq_ctrl dut (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  bit finished = 0;

  // behavioural reference state
  bit m_fl[3];
  bit m_en[3];
  bit m_ts[2];
  bit m_mk[2];
  bit m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_fl[i]) begin m_fl[i] = 0; m_en[i] = 0; end
      m_ts[0] = 0; m_ts[1] = 0; m_mk[0] = 1; m_mk[1] = 1; m_irq = 0;
    end else begin
      bit active, certok, upd, pend;
      bit setr[3];
      m_irq = (m_ts[0] && !m_mk[0]) || (m_ts[1] && !m_mk[1]);
      active = !soft_rst && src_en && osc_en;
      certok = active && (HWV >= 16'h0200 || qtu_en);
      setr[0] = done_ev;
      setr[1] = hlth_fault_ev && active;
      setr[2] = cert_fault_ev && certok;
      if (ctl_we) for (int i = 0; i < 3; i++) m_en[i] = ctl_wdata[i];
      for (int i = 0; i < 3; i++) begin
        bit clr;
        clr = ctl_we && ctl_wdata[3+i];
        if (soft_rst) m_fl[i] = 0;
        else if (setr[i]) m_fl[i] = 1;
        else if (clr) m_fl[i] = 0;
      end
      upd = ctl_we || setr[0] || setr[1] || setr[2];
      pend = 0;
      for (int i = 0; i < 3; i++) if (m_fl[i] && m_en[i]) pend = 1;
      if (soft_rst) m_ts[0] = 0;
      else if (upd) m_ts[0] = pend;
      else if (sts_we && sts_wdata[0]) m_ts[0] = 0;
      if (slv_err_ev) m_ts[1] = 1;
      else if (sts_we && sts_wdata[1]) m_ts[1] = 0;
      for (int i = 0; i < 2; i++) begin
        if (unmask_we && unmask_wdata[i]) m_mk[i] = 0;
        if (mask_we && mask_wdata[i]) m_mk[i] = 1;
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("core_flags", core_flags, {m_fl[2], m_fl[1], m_fl[0]});
      chk("flag_en", flag_en, {m_en[2], m_en[1], m_en[0]});
      chk("top_status", top_status, {m_ts[1], m_ts[0]});
      chk("mask", mask, {m_mk[1], m_mk[0]});
      chk("irq", irq, m_irq);
    end
  end

  task automatic cyc(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      ctl_we = 0; sts_we = 0; unmask_we = 0; mask_we = 0;
      cert_fault_ev = 0; hlth_fault_ev = 0; done_ev = 0; slv_err_ev = 0;
    end
  endtask

  task automatic ctl(logic [5:0] d); ctl_we = 1; ctl_wdata = d; cyc(); endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    cyc(3);
    rst_n = 1;
    cyc(2);
    chk("R1 mask after reset", mask, 2'b11);
    chk("R1 irq after reset", irq, 0);

    tag = "R2";
    done_ev = 1; cyc(2);
    chk("R2 done flag", core_flags[0], 1);
    src_en = 1; osc_en = 1;
    hlth_fault_ev = 1; cyc(2);
    chk("R2 health flag", core_flags[1], 1);
    qtu_en = 1; cert_fault_ev = 1; cyc(2);
    chk("R2 cert flag", core_flags[2], 1);

    tag = "R5";
    ctl(6'b111_000); cyc();
    chk("R5 flags cleared", core_flags, 3'b000);
    ctl(6'b000_101); cyc();
    chk("R5 enables", flag_en, 3'b101);
    ctl_we = 1; ctl_wdata = 6'b001_101; done_ev = 1; cyc(2);
    chk("R5 event wins over clear", core_flags[0], 1);

    tag = "R4";
    qtu_en = 0; cert_fault_ev = 1; cyc(2);
    chk("R4 cert ignored without qtu", core_flags[2], 0);
    hlth_fault_ev = 1; cyc(2);
    chk("R4 health unaffected", core_flags[1], 1);
    qtu_en = 1;

    tag = "R3";
    ctl(6'b111_101);
    src_en = 0; hlth_fault_ev = 1; cert_fault_ev = 1; cyc(2);
    chk("R3 src_en low", core_flags, 3'b000);
    src_en = 1; osc_en = 0; hlth_fault_ev = 1; cyc(2);
    chk("R3 osc_en low", core_flags[1], 0);
    osc_en = 1; soft_rst = 1; hlth_fault_ev = 1; cyc(2);
    soft_rst = 0; cyc();
    chk("R3 soft reset", core_flags[1], 0);

    tag = "R6";
    ctl(6'b000_001);
    done_ev = 1; cyc(2);
    chk("R6 core int from done", top_status[0], 1);
    sts_we = 1; sts_wdata = 2'b01; cyc(2);
    chk("R6 core int cleared", top_status[0], 0);
    ctl(6'b000_001); cyc();
    chk("R6 recompute on ctl write", top_status[0], 1);
    ctl(6'b000_010); cyc();
    chk("R6 recompute drops", top_status[0], 0);

    tag = "R7";
    slv_err_ev = 1; cyc(2);
    chk("R7 slave error set", top_status[1], 1);
    sts_we = 1; sts_wdata = 2'b10; slv_err_ev = 1; cyc(2);
    chk("R7 set beats clear", top_status[1], 1);
    sts_we = 1; sts_wdata = 2'b10; cyc(2);
    chk("R7 slave error cleared", top_status[1], 0);
    ctl(6'b000_011); cyc();
    sts_we = 1; sts_wdata = 2'b01; hlth_fault_ev = 1; cyc(2);
    chk("R7 recompute beats clear", top_status[0], 1);

    tag = "R8";
    unmask_we = 1; unmask_wdata = 2'b01; cyc(2);
    chk("R8 unmask bit0", mask, 2'b10);
    unmask_we = 1; unmask_wdata = 2'b10; mask_we = 1; mask_wdata = 2'b10; cyc(2);
    chk("R8 disable wins", mask, 2'b10);

    tag = "R9";
    cyc(2);
    chk("R9 irq from core int", irq, 1);
    mask_we = 1; mask_wdata = 2'b01; cyc(2);
    chk("R9 irq masked", irq, 0);
    unmask_we = 1; unmask_wdata = 2'b10; slv_err_ev = 1; cyc();
    chk("R9 irq not yet", irq, 0);
    cyc();
    chk("R9 irq slave error", irq, 1);

    tag = "R10";
    soft_rst = 1; cyc(2);
    chk("R10 flags cleared", core_flags, 3'b000);
    chk("R10 core int cleared", top_status[0], 0);
    chk("R10 mask kept", mask, 2'b01);
    chk("R10 enables kept", flag_en, 3'b011);
    chk("R10 slave error kept", top_status[1], 1);
    soft_rst = 0; cyc(3);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule